// File: doc/BRIEF.md
# Next-PC unit with branch delay slot

This block holds the program counter of a 32-bit load/store processor and works out the address of the next instruction. The instruction decoder gives it a two-bit select code each cycle. The select code asks for one of four actions: step to the next word, take a PC-relative branch (gated by a taken flag from the comparison logic), jump to an absolute target inside the current 256 MB region, or jump to an address held in a register. The unit also gives the return address that link-type instructions write back. The register file chooses the destination register for that write, so it is not decided here.

Each redirect is delayed by one instruction. The instruction at the word after a branch or jump is always fetched and executed first, and only then does the program counter move to the target. The control is a three-state machine:
- **RUN** is normal fetch.
- **SLOT** is the cycle in which the delay-slot instruction is the current one.
- **HALT** is entered when the program counter reaches address zero.

The transitions are as follows:
- RUN goes to SLOT on any redirect.
- RUN goes to HALT when the next sequential address is zero.
- SLOT goes back to RUN when the saved target is non-zero.
- SLOT goes to HALT when the saved target is zero.
- HALT stays in HALT until reset.
- Reset places the machine in RUN at the boot address.

Top module: `npc_unit`

## Requirements
- R1: While reset is high at a clock edge, the PC loads 0xBFC00000 and the halt flag clears. Any redirect that was saved before the reset is dropped.
- R2: With select code 0 (step) in RUN, the PC advances by 4 at the next edge.
- R3: With select code 1 (branch) and the taken flag high in RUN, the PC first advances by 4 (the delay slot). At the following edge it moves to that slot address plus the sign-extended offset shifted left by two. Negative offsets are included.
- R4: With select code 1 and the taken flag low, the PC advances by 4 and no redirect follows.
- R5: With select code 2 (region jump), after the delay slot the PC becomes the top 4 bits of the slot address, followed by the 26-bit index, followed by two zero bits. A slot that falls in the next region therefore selects that region.
- R6: With select code 3 (register jump), after the delay slot the PC becomes the register operand value.
- R7: The link output always equals the current PC plus 8, which is the address just past the delay slot.
- R8: Select code, taken flag and operands applied during the delay-slot cycle have no effect. The PC still goes to the target that was saved before the slot.
- R9: When the PC becomes 0x00000000, the halt flag rises in the same cycle. After that, the PC stays at zero and the flag stays high whatever the inputs are, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_sel | input | 2 | Next-PC select: 0 step, 1 branch, 2 region jump, 3 register jump |
| br_taken | input | 1 | Branch condition result, used with select code 1 |
| br_offset | input | 32 | Sign-extended 16-bit branch offset, in words |
| jump_index | input | 26 | Word index of a region jump |
| reg_target | input | 32 | Register operand for a register jump |
| pc | output | 32 | Address of the current instruction |
| link_addr | output | 32 | Return address, PC plus 8 |
| halted | output | 1 | High once the PC has reached address zero |

## Verification
The PC is a register. A step or the delay-slot address therefore appears one edge after its select code is presented, and a redirect target appears two edges after it. The halt flag changes at the same edge on which the PC reaches zero. The link output is combinational from the PC and is valid in the same cycle as the PC. The bench changes inputs 2 ns after an edge and reads every output 2 ns after the next edge. A redirect is therefore checked first at its slot address and then at its target, one stimulus later. The stimulus applied between those two edges is deliberately chosen to be conflicting, so that any effect it has would show.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Select code driven by the decoder
    typedef enum logic [1:0] {
        SEL_STEP   = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_JUMP   = 2'd2,
        SEL_REG    = 2'd3
    } pc_sel_e;

    // Control states
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SLOT = 2'd1,
        ST_HALT = 2'd2
    } npc_state_e;

    // Source of the next PC value
    typedef enum logic [1:0] {
        SRC_STEP = 2'd0,
        SRC_PEND = 2'd1,
        SRC_HOLD = 2'd2
    } pc_src_e;

endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]      pc,
    input  npc_pkg::pc_sel_e     sel,
    input  logic                 br_taken,
    input  logic [XLEN-1:0]      br_offset,
    input  logic [IDX_W-1:0]     jump_index,
    input  logic [XLEN-1:0]      reg_target,
    output logic [XLEN-1:0]      step_addr,
    output logic [XLEN-1:0]      link_addr,
    output logic [XLEN-1:0]      redir_addr,
    output logic                 redirect
);
    import npc_pkg::*;

    localparam int REGION_W = XLEN - IDX_W - 2;
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;

    always_comb begin
        step_addr = pc + WORD_BYTES;
        link_addr = step_addr + WORD_BYTES;
        br_tgt    = step_addr + (br_offset << 2);
        jmp_tgt   = {step_addr[XLEN-1 -: REGION_W], jump_index, 2'b00};
    end

    always_comb begin
        redirect   = 1'b0;
        redir_addr = step_addr;
        unique case (sel)
            SEL_STEP: begin
                redirect   = 1'b0;
                redir_addr = step_addr;
            end
            SEL_BRANCH: begin
                redirect   = br_taken;
                redir_addr = br_tgt;
            end
            SEL_JUMP: begin
                redirect   = 1'b1;
                redir_addr = jmp_tgt;
            end
            SEL_REG: begin
                redirect   = 1'b1;
                redir_addr = reg_target;
            end
            default: begin
                redirect   = 1'b0;
                redir_addr = step_addr;
            end
        endcase
    end

endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  redirect,
    input  logic                  step_is_halt,
    input  logic                  pend_is_halt,
    output npc_pkg::npc_state_e   state,
    output npc_pkg::pc_src_e      src,
    output logic                  capture,
    output logic                  halted
);
    import npc_pkg::*;

    npc_state_e st_q;
    npc_state_e st_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (step_is_halt) begin
                    st_d = ST_HALT;
                end else if (redirect) begin
                    st_d = ST_SLOT;
                end else begin
                    st_d = ST_RUN;
                end
            end
            ST_SLOT: begin
                st_d = pend_is_halt ? ST_HALT : ST_RUN;
            end
            ST_HALT: begin
                st_d = ST_HALT;
            end
            default: begin
                st_d = ST_RUN;
            end
        endcase
    end

    // Outputs
    always_comb begin
        src     = SRC_STEP;
        capture = 1'b0;
        halted  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                src     = SRC_STEP;
                capture = redirect;
            end
            ST_SLOT: begin
                src = SRC_PEND;
            end
            ST_HALT: begin
                src    = SRC_HOLD;
                halted = 1'b1;
            end
            default: begin
                src = SRC_STEP;
            end
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int               XLEN      = 32,
    parameter int               IDX_W     = 26,
    parameter logic [XLEN-1:0]  RESET_VEC = 32'hBFC0_0000,
    parameter logic [XLEN-1:0]  HALT_ADDR = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pc_sel,
    input  logic              br_taken,
    input  logic [XLEN-1:0]   br_offset,
    input  logic [IDX_W-1:0]  jump_index,
    input  logic [XLEN-1:0]   reg_target,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   link_addr,
    output logic              halted
);
    import npc_pkg::*;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pend_q;
    logic [XLEN-1:0] pc_d;
    logic [XLEN-1:0] step_addr;
    logic [XLEN-1:0] redir_addr;
    logic            redirect;
    logic            capture;
    pc_src_e         src;
    npc_state_e      state;

    npc_targets #(
        .XLEN  (XLEN),
        .IDX_W (IDX_W)
    ) u_targets (
        .pc         (pc_q),
        .sel        (pc_sel_e'(pc_sel)),
        .br_taken   (br_taken),
        .br_offset  (br_offset),
        .jump_index (jump_index),
        .reg_target (reg_target),
        .step_addr  (step_addr),
        .link_addr  (link_addr),
        .redir_addr (redir_addr),
        .redirect   (redirect)
    );

    npc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .redirect     (redirect),
        .step_is_halt (step_addr == HALT_ADDR),
        .pend_is_halt (pend_q == HALT_ADDR),
        .state        (state),
        .src          (src),
        .capture      (capture),
        .halted       (halted)
    );

    always_comb begin
        unique case (src)
            SRC_STEP: pc_d = step_addr;
            SRC_PEND: pc_d = pend_q;
            SRC_HOLD: pc_d = pc_q;
            default:  pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= RESET_VEC;
            pend_q <= RESET_VEC;
        end else begin
            pc_q <= pc_d;
            if (capture) begin
                pend_q <= redir_addr;
            end
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int               XLEN      = 32,
    parameter logic [XLEN-1:0]  HALT_ADDR = 32'h0000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           pc_sel,
    input  logic                 br_taken,
    input  logic [XLEN-1:0]      br_offset,
    input  logic [XLEN-1:0]      reg_target,
    input  logic [XLEN-1:0]      pc,
    input  logic                 halted,
    input  npc_pkg::npc_state_e  st
);
    import npc_pkg::*;

    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

    logic redir;
    logic in_run;
    logic slot_ok;
    assign redir   = (pc_sel == 2'd2) || (pc_sel == 2'd3) || ((pc_sel == 2'd1) && br_taken);
    assign in_run  = (st == ST_RUN);
    assign slot_ok = ((pc + WORD_BYTES) != HALT_ADDR);

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (in_run && !redir) |=> (pc == $past(pc) + WORD_BYTES)); // R2

    AST_SLOT_FETCHED: assert property (@(posedge clk) disable iff (rst)
        (in_run && redir) |=> (pc == $past(pc) + WORD_BYTES)); // R3

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        (in_run && pc_sel == 2'd1 && br_taken && slot_ok) |=> ##1
        (pc == $past(pc, 2) + WORD_BYTES + ($past(br_offset, 2) << 2))); // R3

    AST_REG_TARGET: assert property (@(posedge clk) disable iff (rst)
        (in_run && pc_sel == 2'd3 && slot_ok) |=> ##1 (pc == $past(reg_target, 2))); // R6

    AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SLOT) |=> (st != ST_SLOT)); // R8

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && pc == HALT_ADDR)); // R9

    AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pc == HALT_ADDR) |-> halted); // R9

endmodule

bind npc_unit npc_unit_chk #(
    .XLEN      (XLEN),
    .HALT_ADDR (HALT_ADDR)
) u_npc_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_sel     (pc_sel),
    .br_taken   (br_taken),
    .br_offset  (br_offset),
    .reg_target (reg_target),
    .pc         (pc),
    .halted     (halted),
    .st         (state)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  pc_sel = 2'd0;
    logic        br_taken = 1'b0;
    logic [31:0] br_offset = 32'h0;
    logic [25:0] jump_index = 26'h0;
    logic [31:0] reg_target = 32'h0;
    logic [31:0] pc;
    logic [31:0] link_addr;
    logic        halted;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    npc_unit i_npc_unit (
        .clk        (clk),
        .rst        (rst),
        .pc_sel     (pc_sel),
        .br_taken   (br_taken),
        .br_offset  (br_offset),
        .jump_index (jump_index),
        .reg_target (reg_target),
        .pc         (pc),
        .link_addr  (link_addr),
        .halted     (halted)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic        taken;
        logic [31:0] off;
        logic [25:0] idx;
        logic [31:0] rv;
        logic [31:0] exp_pc;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{2'd0, 1'b0, 32'h0000_0000, 26'h000_0000, 32'h0000_0000, 32'hBFC0_0004}, // R2 step
        '{2'd1, 1'b0, 32'h0000_0005, 26'h000_0000, 32'h0000_0000, 32'hBFC0_0008}, // R4 not taken
        '{2'd1, 1'b1, 32'h0000_0003, 26'h000_0000, 32'h0000_0000, 32'hBFC0_000C}, // R3 slot
        '{2'd2, 1'b0, 32'h0000_0000, 26'h000_0155, 32'h0000_0000, 32'hBFC0_0018}, // R3 target, R8 jump ignored
        '{2'd1, 1'b1, 32'hFFFF_FFFE, 26'h000_0000, 32'h0000_0000, 32'hBFC0_001C}, // R3 backward slot
        '{2'd0, 1'b0, 32'h0000_0000, 26'h000_0000, 32'h0000_0000, 32'hBFC0_0014}, // R3 negative offset
        '{2'd2, 1'b0, 32'h0000_0000, 26'h000_0100, 32'h0000_0000, 32'hBFC0_0018}, // R5 slot
        '{2'd3, 1'b0, 32'h0000_0000, 26'h000_0000, 32'h0000_0000, 32'hB000_0400}, // R5 target, R8 reg jump ignored
        '{2'd3, 1'b0, 32'h0000_0000, 26'h000_0000, 32'h8000_1230, 32'hB000_0404}, // R6 slot
        '{2'd0, 1'b0, 32'h0000_0000, 26'h000_0000, 32'h0000_0000, 32'h8000_1230}, // R6 target
        '{2'd2, 1'b0, 32'h0000_0000, 26'h3FF_FFFF, 32'h0000_0000, 32'h8000_1234}, // R5 slot
        '{2'd1, 1'b1, 32'h0000_0007, 26'h000_0000, 32'h0000_0000, 32'h8FFF_FFFC}, // R5 all-ones index, R8 branch ignored
        '{2'd2, 1'b0, 32'h0000_0000, 26'h000_0010, 32'h0000_0000, 32'h9000_0000}, // R5 slot crosses region
        '{2'd0, 1'b0, 32'h0000_0000, 26'h000_0000, 32'h0000_0000, 32'h9000_0040}  // R5 region from slot address
    };

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] s, input logic t, input logic [31:0] o,
                        input logic [25:0] x, input logic [31:0] r);
        pc_sel     = s;
        br_taken   = t;
        br_offset  = o;
        jump_index = x;
        reg_target = r;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #2;
        check32("R1 reset pc", pc, 32'hBFC0_0000);
        check32("R1 reset halted", {31'b0, halted}, 32'h0);
        check32("R7 link at reset", link_addr, 32'hBFC0_0008);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].sel, VECS[i].taken, VECS[i].off, VECS[i].idx, VECS[i].rv);
            check32($sformatf("vector %0d pc", i), pc, VECS[i].exp_pc);
            check32($sformatf("R7 vector %0d link", i), link_addr, VECS[i].exp_pc + 32'd8);
            check32($sformatf("R9 vector %0d halted low", i), {31'b0, halted}, 32'h0);
        end

        // R9: register jump through zero halts after the slot
        step(2'd3, 1'b0, 32'h0, 26'h0, 32'h0);
        check32("R9 slot before halt pc", pc, 32'h9000_0044);
        check32("R9 slot before halt flag", {31'b0, halted}, 32'h0);
        step(2'd0, 1'b0, 32'h0, 26'h0, 32'h0);
        check32("R9 halt pc", pc, 32'h0);
        check32("R9 halt flag", {31'b0, halted}, 32'h1);
        step(2'd2, 1'b0, 32'h0, 26'h0AB_CDEF, 32'h0);
        check32("R9 jump ignored when halted", pc, 32'h0);
        step(2'd3, 1'b0, 32'h0, 26'h0, 32'h1234_5678);
        check32("R9 reg jump ignored when halted", pc, 32'h0);
        step(2'd1, 1'b1, 32'h0000_0010, 26'h0, 32'h0);
        check32("R9 branch ignored when halted", pc, 32'h0);
        check32("R9 flag held", {31'b0, halted}, 32'h1);

        // R1: reset leaves halt
        rst = 1'b1;
        @(posedge clk);
        #2;
        check32("R1 reset from halt pc", pc, 32'hBFC0_0000);
        check32("R1 reset from halt flag", {31'b0, halted}, 32'h0);
        rst = 1'b0;

        // R1: reset in the delay slot drops the saved target
        step(2'd2, 1'b0, 32'h0, 26'h000_0020, 32'h0);
        check32("R1 slot before reset", pc, 32'hBFC0_0004);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check32("R1 reset in slot pc", pc, 32'hBFC0_0000);
        rst = 1'b0;
        step(2'd0, 1'b0, 32'h0, 26'h0, 32'h0);
        check32("R1 saved target dropped", pc, 32'hBFC0_0004);
        step(2'd0, 1'b0, 32'h0, 26'h0, 32'h0);
        check32("R2 step after reset", pc, 32'hBFC0_0008);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule